// File: doc/BRIEF.md
# Offload Control and Status Register Bank

This block is the software-visible register file of a buffer offload engine. A host issues word-addressed reads and writes over a simple request bus. The block then drives the datapath's control inputs: soft reset, single-pass playback, pass-through, synchronisation mode, a software start pulse and the transfer length. It also collects what the datapath reports: overflow and underflow events, the memory calibration flag, and the two state-machine codes.

Read data is registered. It appears on `bus_rdata` in the cycle after the read request and holds until the next read. Some read-only words are fixed constants. Others come from synthesis parameters, as do several reset values. The overflow and underflow flags are sticky and are cleared by writing 1.

Top module: `offload_regs`

## Requirements
- R1: A read request (bus_en=1, bus_wr=0) returns its word on bus_rdata after the next rising clock edge. Word 0x000 reads 0x00010061, with major=1 in bits 31:16, minor=0 in bits 15:8 and patch=0x61 in bits 7:0. Word 0x003 reads 0x44414F46.
- R2: Word 0x004 reads {29'b0, HAS_BYPASS, TX_PATH, EXT_MEM}. With the defaults (1,1,0) this is 0x6. Word 0x005 holds the low 32 bits of 2^MEM_SIZE_LOG2 and word 0x006 bits 1:0 hold the next two bits. With the default MEM_SIZE_LOG2=10 these are 0x400 and 0.
- R3: Word 0x002 is a 32-bit read/write scratch register that resets to 0.
- R4: Word 0x007 is the read/write transfer length, counted in 64-byte units. It resets to (2^MEM_SIZE_LOG2-1)>>6, which is 15 by default, and it drives xfer_len.
- R5: In word 0x020, bit 4 latches an overflow pulse and bit 5 latches an underflow pulse. Each bit stays set until a write with a 1 in that bit position. Writing 0 there leaves the bit unchanged.
- R6: An event pulse in the same cycle as a write-1 clear of its bit leaves that bit set.
- R7: Word 0x020 bit 0 reflects hw_calib_done. Word 0x080 reads hw_rd_state in bits 11:8 and hw_wr_state in bits 4:0.
- R8: Word 0x021 bit 0 is the active-low soft reset. It resets to AUTO_BRINGUP (1 by default) and drives soft_rst_n.
- R9: In word 0x022, bit 1 is single-pass enable, which resets to ~TX_PATH (0 by default) and drives oneshot_en. Bit 0 is pass-through enable, which resets to 0 and drives bypass_en.
- R10: Word 0x041 bits 1:0 are the read/write sync mode, which resets to 0 and drives sync_mode. Writing 1 to word 0x040 bit 0 makes sw_trigger high for exactly the one cycle after the write edge. Word 0x040 reads 0.
- R11: Reads of unmapped words return 0. Writes to read-only or unmapped words change no register.
- R12: Control outputs change only on a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_en | input | 1 | Request valid |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| hw_overflow | input | 1 | Overflow event pulse |
| hw_underflow | input | 1 | Underflow event pulse |
| hw_calib_done | input | 1 | Memory calibration complete level |
| hw_rd_state | input | 4 | Read-side state code |
| hw_wr_state | input | 5 | Write-side state code |
| soft_rst_n | output | 1 | Datapath soft reset, active low |
| oneshot_en | output | 1 | Single-pass playback enable |
| bypass_en | output | 1 | Pass-through enable |
| sync_mode | output | 2 | Synchronisation mode select |
| sw_trigger | output | 1 | One-cycle software start pulse |
| xfer_len | output | 32 | Transfer length in 64-byte units |

## Verification
Reads are tried on every mapped word right after reset. This separates parameter-derived values from fixed constants and from reset-time register values. Writes of patterns with alternating bits and of all ones follow, which exposes stuck or swapped bits in the read/write fields. Writes aimed at read-only and unmapped words show whether address decoding leaks.

Event pulses are driven alone, together with a matching clear, and with writes of 0. These three cases tell stickiness, clear priority and write-1 semantics apart. A software trigger write is followed cycle by cycle to confirm that the pulse lasts exactly one cycle.

// File: rtl/offload_regs.sv
module offload_regs #(
  parameter int          ADDR_W        = 8,
  parameter int          MEM_SIZE_LOG2 = 10,
  parameter bit          HAS_BYPASS    = 1'b1,
  parameter bit          TX_PATH       = 1'b1,
  parameter bit          EXT_MEM       = 1'b0,
  parameter bit          AUTO_BRINGUP  = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              hw_overflow,
  input  logic              hw_underflow,
  input  logic              hw_calib_done,
  input  logic [3:0]        hw_rd_state,
  input  logic [4:0]        hw_wr_state,
  output logic              soft_rst_n,
  output logic              oneshot_en,
  output logic              bypass_en,
  output logic [1:0]        sync_mode,
  output logic              sw_trigger,
  output logic [31:0]       xfer_len
);
  localparam logic [33:0] MEM_BYTES = 34'd1 << MEM_SIZE_LOG2;
  localparam logic [33:0] LEN_INIT  = (MEM_BYTES - 34'd1) >> 6;
  localparam logic [31:0] VERSION   = 32'h0001_0061;
  localparam logic [31:0] IDENT     = 32'h4441_4F46;

  localparam logic [ADDR_W-1:0] A_VER   = ADDR_W'(12'h000);
  localparam logic [ADDR_W-1:0] A_SCR   = ADDR_W'(12'h002);
  localparam logic [ADDR_W-1:0] A_IDENT = ADDR_W'(12'h003);
  localparam logic [ADDR_W-1:0] A_CFG   = ADDR_W'(12'h004);
  localparam logic [ADDR_W-1:0] A_SZLO  = ADDR_W'(12'h005);
  localparam logic [ADDR_W-1:0] A_SZHI  = ADDR_W'(12'h006);
  localparam logic [ADDR_W-1:0] A_LEN   = ADDR_W'(12'h007);
  localparam logic [ADDR_W-1:0] A_STAT  = ADDR_W'(12'h020);
  localparam logic [ADDR_W-1:0] A_SRST  = ADDR_W'(12'h021);
  localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(12'h022);
  localparam logic [ADDR_W-1:0] A_TRIG  = ADDR_W'(12'h040);
  localparam logic [ADDR_W-1:0] A_SYNC  = ADDR_W'(12'h041);
  localparam logic [ADDR_W-1:0] A_FSM   = ADDR_W'(12'h080);

  logic [31:0] scratch_q;
  logic        ovf_q, unf_q;
  logic [31:0] rd_mux;

  wire wr_en = bus_en & bus_wr;
  wire rd_en = bus_en & ~bus_wr;
  wire wr_stat = wr_en && bus_addr == A_STAT;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scratch_q  <= '0;
      xfer_len   <= LEN_INIT[31:0];
      soft_rst_n <= AUTO_BRINGUP;
      oneshot_en <= ~TX_PATH;
      bypass_en  <= 1'b0;
      sync_mode  <= 2'd0;
    end else if (wr_en) begin
      case (bus_addr)
        A_SCR:  scratch_q  <= bus_wdata;
        A_LEN:  xfer_len   <= bus_wdata;
        A_SRST: soft_rst_n <= bus_wdata[0];
        A_CTRL: {oneshot_en, bypass_en} <= bus_wdata[1:0];
        A_SYNC: sync_mode  <= bus_wdata[1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ovf_q      <= 1'b0;
      unf_q      <= 1'b0;
      sw_trigger <= 1'b0;
    end else begin
      ovf_q      <= hw_overflow  | (ovf_q & ~(wr_stat & bus_wdata[4]));
      unf_q      <= hw_underflow | (unf_q & ~(wr_stat & bus_wdata[5]));
      sw_trigger <= wr_en && bus_addr == A_TRIG && bus_wdata[0];
    end
  end

  always_comb begin
    rd_mux = '0;
    case (bus_addr)
      A_VER:   rd_mux = VERSION;
      A_SCR:   rd_mux = scratch_q;
      A_IDENT: rd_mux = IDENT;
      A_CFG:   rd_mux = {29'd0, HAS_BYPASS, TX_PATH, EXT_MEM};
      A_SZLO:  rd_mux = MEM_BYTES[31:0];
      A_SZHI:  rd_mux = {30'd0, MEM_BYTES[33:32]};
      A_LEN:   rd_mux = xfer_len;
      A_STAT:  rd_mux = {26'd0, unf_q, ovf_q, 3'd0, hw_calib_done};
      A_SRST:  rd_mux = {31'd0, soft_rst_n};
      A_CTRL:  rd_mux = {30'd0, oneshot_en, bypass_en};
      A_SYNC:  rd_mux = {30'd0, sync_mode};
      A_FSM:   rd_mux = {20'd0, hw_rd_state, 3'd0, hw_wr_state};
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     bus_rdata <= '0;
    else if (rd_en) bus_rdata <= rd_mux;
  end
endmodule

// File: rtl/offload_regs_chk.sv
module offload_regs_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_en,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic [31:0]       bus_rdata,
  input logic              hw_overflow,
  input logic              ovf_q,
  input logic              unf_q,
  input logic              soft_rst_n,
  input logic              oneshot_en,
  input logic              bypass_en,
  input logic [1:0]        sync_mode,
  input logic              sw_trigger,
  input logic [31:0]       xfer_len
);
  function automatic bit mapped(input logic [ADDR_W-1:0] a);
    case (int'(a))
      'h000, 'h002, 'h003, 'h004, 'h005, 'h006, 'h007,
      'h020, 'h021, 'h022, 'h040, 'h041, 'h080: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  wire clr_ovf = bus_en && bus_wr && int'(bus_addr) == 'h020 && bus_wdata[4];
  wire trig_wr = bus_en && bus_wr && int'(bus_addr) == 'h040 && bus_wdata[0];

  AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    hw_overflow |=> ovf_q); // R6
  AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_q && !clr_ovf) |=> ovf_q); // R5
  AST_TRIG_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    sw_trigger |-> $past(trig_wr)); // R10
  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && !bus_wr && !mapped(bus_addr)) |=> bus_rdata == 32'd0); // R11
  AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_en && bus_wr) |=> $stable({soft_rst_n, oneshot_en, bypass_en, sync_mode, xfer_len})); // R12
  AST_UNF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (unf_q && !bus_en) |=> unf_q); // R5
endmodule

bind offload_regs offload_regs_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .hw_overflow(hw_overflow), .ovf_q(ovf_q), .unf_q(unf_q),
  .soft_rst_n(soft_rst_n), .oneshot_en(oneshot_en), .bypass_en(bypass_en),
  .sync_mode(sync_mode), .sw_trigger(sw_trigger), .xfer_len(xfer_len)
);

// File: tb/offload_regs_tb_top.sv
module offload_regs_tb_top;
  localparam int PER = 10;

  logic        clk = 0, rst_n = 0;
  logic        bus_en = 0, bus_wr = 0;
  logic [7:0]  bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic        hw_overflow = 0, hw_underflow = 0, hw_calib_done = 0;
  logic [3:0]  hw_rd_state = 0;
  logic [4:0]  hw_wr_state = 0;
  logic        soft_rst_n, oneshot_en, bypass_en, sw_trigger;
  logic [1:0]  sync_mode;
  logic [31:0] xfer_len;

  int total = 0, bad = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #(PER/2) clk = ~clk;

  offload_regs dut_i (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .hw_overflow(hw_overflow), .hw_underflow(hw_underflow),
    .hw_calib_done(hw_calib_done), .hw_rd_state(hw_rd_state),
    .hw_wr_state(hw_wr_state), .soft_rst_n(soft_rst_n),
    .oneshot_en(oneshot_en), .bypass_en(bypass_en), .sync_mode(sync_mode),
    .sw_trigger(sw_trigger), .xfer_len(xfer_len)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_en = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 0; bus_wr = 0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag);
    @(negedge clk);
    bus_en = 1; bus_wr = 0; bus_addr = a;
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk);
    bus_en = 0;
  endtask

  // monitor: a read seen at an edge is compared a quarter period later
  initial begin
    forever begin
      @(posedge clk);
      if (rst_n && bus_en && !bus_wr) begin
        #(PER/4);
        if (exp_q.size() == 0) begin
          total++; bad++;
          $display("FAIL scoreboard unexpected read actual=%h expected=none", bus_rdata);
        end else begin
          logic [31:0] e;
          string t;
          e = exp_q.pop_front(); t = tag_q.pop_front();
          check(t, bus_rdata, e);
        end
      end
    end
  end

  initial begin
    #(PER*100000);
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R8 soft_rst_n reset", {31'd0, soft_rst_n}, 32'd1);
    check("R9 oneshot reset", {31'd0, oneshot_en}, 32'd0);
    check("R9 bypass reset", {31'd0, bypass_en}, 32'd0);
    check("R10 sync_mode reset", {30'd0, sync_mode}, 32'd0);
    check("R4 xfer_len reset", xfer_len, 32'd15);

    rd(8'h00, 32'h0001_0061, "R1 version");
    rd(8'h03, 32'h4441_4F46, "R1 ident");
    rd(8'h04, 32'h6, "R2 config bits");
    rd(8'h05, 32'h400, "R2 size low");
    rd(8'h06, 32'h0, "R2 size high");
    rd(8'h02, 32'h0, "R3 scratch reset");
    rd(8'h07, 32'd15, "R4 length reset");
    rd(8'h20, 32'h0, "R5 status reset");

    wr(8'h02, 32'hA5A5_5A5A);
    rd(8'h02, 32'hA5A5_5A5A, "R3 scratch pattern");
    wr(8'h02, 32'hFFFF_FFFF);
    rd(8'h02, 32'hFFFF_FFFF, "R3 scratch ones");
    wr(8'h07, 32'h0000_1234);
    check("R4 xfer_len port", xfer_len, 32'h1234);
    rd(8'h07, 32'h1234, "R4 length readback");

    @(negedge clk); hw_overflow = 1;
    @(negedge clk); hw_overflow = 0;
    rd(8'h20, 32'h10, "R5 overflow latched");
    wr(8'h20, 32'h0);
    rd(8'h20, 32'h10, "R5 write zero keeps");
    @(negedge clk); hw_underflow = 1;
    @(negedge clk); hw_underflow = 0;
    rd(8'h20, 32'h30, "R5 both latched");
    wr(8'h20, 32'h10);
    rd(8'h20, 32'h20, "R5 overflow cleared alone");
    wr(8'h20, 32'h20);
    rd(8'h20, 32'h0, "R5 underflow cleared");

    @(negedge clk);
    hw_overflow = 1; bus_en = 1; bus_wr = 1; bus_addr = 8'h20; bus_wdata = 32'h10;
    @(negedge clk);
    hw_overflow = 0; bus_en = 0; bus_wr = 0;
    rd(8'h20, 32'h10, "R6 event beats clear");
    wr(8'h20, 32'h10);

    hw_calib_done = 1; hw_rd_state = 4'hA; hw_wr_state = 5'h13;
    rd(8'h20, 32'h1, "R7 calib flag");
    rd(8'h80, 32'h0000_0A13, "R7 state codes");

    wr(8'h21, 32'h0);
    check("R8 soft reset asserted", {31'd0, soft_rst_n}, 32'd0);
    rd(8'h21, 32'h0, "R8 soft reset readback");
    wr(8'h21, 32'h1);
    check("R8 soft reset released", {31'd0, soft_rst_n}, 32'd1);

    wr(8'h22, 32'h2);
    check("R9 oneshot set", {30'd0, oneshot_en, bypass_en}, 32'h2);
    wr(8'h22, 32'h1);
    check("R9 bypass set", {30'd0, oneshot_en, bypass_en}, 32'h1);
    rd(8'h22, 32'h1, "R9 control readback");

    wr(8'h41, 32'h2);
    check("R10 sync_mode", {30'd0, sync_mode}, 32'h2);
    rd(8'h41, 32'h2, "R10 sync readback");
    check("R10 trigger idle", {31'd0, sw_trigger}, 32'd0);
    wr(8'h40, 32'h1);
    check("R10 trigger pulse", {31'd0, sw_trigger}, 32'd1);
    @(negedge clk);
    check("R10 trigger one cycle", {31'd0, sw_trigger}, 32'd0);
    rd(8'h40, 32'h0, "R10 trigger reads zero");

    rd(8'h01, 32'h0, "R11 unmapped 0x01");
    rd(8'hFF, 32'h0, "R11 unmapped 0xFF");
    wr(8'h03, 32'h0);
    rd(8'h03, 32'h4441_4F46, "R11 ident write ignored");
    wr(8'h05, 32'h0);
    rd(8'h05, 32'h400, "R11 size write ignored");
    wr(8'h30, 32'hFFFF_FFFF);
    check("R11 unmapped write outputs", {soft_rst_n, oneshot_en, bypass_en, sync_mode, xfer_len[26:0]},
          {1'b1, 1'b0, 1'b1, 2'h2, 27'h1234});
    rd(8'h02, 32'hFFFF_FFFF, "R11 scratch untouched");

    repeat (4) @(negedge clk);
    check("R12 outputs held idle", {30'd0, oneshot_en, bypass_en}, 32'h1);
    check("scoreboard drained", exp_q.size(), 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule